// File: doc/BRIEF.md
# Binary Extension Field Multiply-Accumulate Unit

This block multiplies two elements of a binary extension field GF(2^m), reduces the product by a programmable irreducible polynomial, and XORs a third operand into the result. Addition in such a field is plain XOR, so this one operation covers multiply, multiply-add and, with a zero addend, a bare multiply. It is the arithmetic core used by Reed-Solomon coders, block-cipher S-box work and FFT-style transforms over GF(2^m).

The field is chosen by writing one XLEN-bit configuration word. The degree of the field, the low coefficients of the polynomial and an element mask are decoded once, when the word is written, and kept in hidden registers. Each operation then uses them directly. A degree-XLEN polynomial needs XLEN+1 coefficients. It still fits in XLEN bits because an irreducible polynomial of degree above 1 always has its constant term set. A clear bit 0 in the word therefore means "the top coefficient sits at bit XLEN, and bit 0 is really 1".

An operation starts with a one-cycle `start` pulse. It then processes one multiplier bit per clock, so it takes as many cycles as the field degree. `busy` is high while it runs. `done` pulses for one cycle when the result is written, and the result is held until the next operation completes.

Top module: `gfm_mac`

## Requirements
- R1: After reset `busy`, `done` and `result` are 0, and the field is the degree-1 field GF(2) (polynomial x).
- R2: A configuration word of 0, 1 or 2 selects degree 1 with polynomial x, so the result is (a[0] AND b[0]) XOR c[0] in bit 0 with all other bits 0.
- R3: A configuration word of 3 or more with bit 0 set selects degree d = index of its highest set bit. The polynomial is x^d plus the coefficients held in bits d-1..0 of the word.
- R4: A configuration word of 3 or more with bit 0 clear selects degree XLEN. The polynomial is x^XLEN plus bits XLEN-1..1 of the word, with the constant coefficient forced to 1.
- R5: `result` equals (A·B mod g(x)) XOR C, where A, B and C are `op_a`, `op_b` and `op_c` with every bit at or above the degree ignored. The result never has a bit set at or above the degree.
- R6: `done` rises exactly d clock cycles after the edge that accepts `start` (d is the degree), stays high for one cycle, and `busy` is high in every cycle between those two edges.
- R7: `result` changes only in a cycle where `done` is high. Operand changes without a new completed operation leave it unchanged.
- R8: A `start` pulse while `busy` is high is ignored: the running operation completes with its original operands.
- R9: A configuration write while `busy` is high, or in the same cycle as `start`, is discarded. Later operations use the previous field.
- R10: With configuration word 0b1011 (degree 3), 0b111 times 0b101 gives 0b110.
- R11: With configuration word 0x1A (XLEN = 8, meaning x^8+x^4+x^3+x+1), 0x80 times 0x83 gives 0x01.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the field configuration word |
| cfg_poly | input | XLEN | Field configuration word (packed reducing polynomial) |
| start | input | 1 | Begins an operation when the unit is idle |
| op_a | input | XLEN | Multiplicand |
| op_b | input | XLEN | Multiplier |
| op_c | input | XLEN | Addend XORed into the reduced product |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse when `result` is updated |
| result | output | XLEN | Field result, held between operations |

## Verification
The hardest situations to reach from the ports are the collisions with a running operation. These are a configuration write or a second `start` landing while the unit is busy, or a write in the very cycle a `start` is accepted. The stimulus places each of these on a chosen falling edge inside a known operation. It then reads back whether the write took effect from two things: the latency of the next operation, which equals the degree, and that operation's product under the old field. Around this, every one of the 256 configuration words is decoded and exercised with random full-width operands, so each degree and each LSB-clear wide-field case is reached.

// File: rtl/gfm_pkg.sv
// Package: shared types for the GF(2^m) multiply-accumulate unit.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package gfm_pkg;

    // Sequencer state of the iterative multiplier.
    typedef enum logic [0:0] {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_e;

endpackage

// File: rtl/gfm_field_cfg.sv
// Module: gfm_field_cfg
// Holds the decoded field description. On an accepted write it decodes the
// packed configuration word once into degree, low polynomial coefficients
// and element mask, so no operation has to decode it again.
// Assumes XLEN >= 2; the write strobe is already qualified by the caller.
module gfm_field_cfg #(
    parameter int XLEN = 8,
    localparam int DW  = $clog2(XLEN + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [XLEN-1:0] wr_word,
    output logic [DW-1:0]   deg_o,
    output logic [XLEN-1:0] red_o,
    output logic [XLEN-1:0] emask_o
);

    logic [DW-1:0]   msb_idx;
    logic [DW-1:0]   deg_n;
    logic [XLEN-1:0] red_n;
    logic [XLEN-1:0] emask_n;

    // Decode the written word into degree, reduction constant and element mask.
    always_comb begin
        msb_idx = '0;
        for (int i = 0; i < XLEN; i++) begin
            if (wr_word[i]) msb_idx = DW'(i);
        end
        if (wr_word < XLEN'(3)) begin
            deg_n = DW'(1);
            red_n = '0;
        end else if (!wr_word[0]) begin
            deg_n = DW'(XLEN);
            red_n = wr_word | XLEN'(1);
        end else begin
            deg_n = msb_idx;
            red_n = wr_word & ~(XLEN'(1) << msb_idx);
        end
        for (int i = 0; i < XLEN; i++) begin
            emask_n[i] = (DW'(i) < deg_n);
        end
    end

    // Store the decoded description; reset selects GF(2) with polynomial x.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            deg_o   <= DW'(1);
            red_o   <= '0;
            emask_o <= XLEN'(1);
        end else if (wr_en) begin
            deg_o   <= deg_n;
            red_o   <= red_n;
            emask_o <= emask_n;
        end
    end

    // R3/R4: stored degree is always within 1..XLEN.
    a_r3_degree_range: assert property (@(posedge clk) disable iff (!rst_n)
        (deg_o >= DW'(1)) && (deg_o <= DW'(XLEN)));

    // R5: reduction constant has no coefficient at or above the degree.
    a_r5_red_in_field: assert property (@(posedge clk) disable iff (!rst_n)
        (red_o & ~emask_o) == '0);

endmodule

// File: rtl/gfm_seq.sv
// Module: gfm_seq
// Sequencer: accepts start when idle, runs for 'degree' step cycles and
// raises done for one cycle on the last step. Assumes deg_i >= 1 and that
// deg_i is held constant while busy.
module gfm_seq
    import gfm_pkg::*;
#(
    parameter int XLEN = 8,
    localparam int DW  = $clog2(XLEN + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [DW-1:0] deg_i,
    output logic          load_o,
    output logic          step_o,
    output logic          last_o,
    output logic          busy_o,
    output logic          done_o
);

    seq_state_e    state_q;
    logic [DW-1:0] left_q;

    // Decode handshake strobes from the current state.
    always_comb begin
        busy_o = (state_q == SEQ_RUN);
        load_o = start_i && !busy_o;
        step_o = busy_o;
        last_o = busy_o && (left_q == DW'(1));
    end

    // Advance the state and the remaining-step counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            left_q  <= '0;
            done_o  <= 1'b0;
        end else begin
            done_o <= last_o;
            if (load_o) begin
                state_q <= SEQ_RUN;
                left_q  <= deg_i;
            end else if (busy_o) begin
                left_q <= left_q - DW'(1);
                if (last_o) state_q <= SEQ_IDLE;
            end
        end
    end

    // R6: done is a single-cycle pulse.
    a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R6: done only follows a busy cycle.
    a_r6_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(busy_o));

    // R6: counter never runs out while busy.
    a_r6_count_live: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (left_q != '0));

    // R8: a start while busy does not reload the counter.
    a_r8_no_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !last_o) |=> (left_q == $past(left_q) - DW'(1)));

endmodule

// File: rtl/gfm_datapath.sv
// Module: gfm_datapath
// Shift-and-add field multiplier, least significant multiplier bit first.
// Each step adds the multiplicand when the multiplier bit is set, then
// multiplies the multiplicand by x and reduces it. Assumes emask/red are
// held constant between load and last.
module gfm_datapath #(
    parameter int XLEN = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load_i,
    input  logic            step_i,
    input  logic            last_i,
    input  logic [XLEN-1:0] a_i,
    input  logic [XLEN-1:0] b_i,
    input  logic [XLEN-1:0] c_i,
    input  logic [XLEN-1:0] red_i,
    input  logic [XLEN-1:0] emask_i,
    output logic [XLEN-1:0] result_o
);

    logic [XLEN-1:0] mcand_q;
    logic [XLEN-1:0] mplier_q;
    logic [XLEN-1:0] acc_q;
    logic [XLEN-1:0] addend_q;
    logic [XLEN-1:0] top_bit;
    logic [XLEN-1:0] acc_n;
    logic [XLEN-1:0] mcand_n;

    // Form the next accumulator and the next multiplicand times x mod g.
    always_comb begin
        top_bit = emask_i ^ (emask_i >> 1);
        acc_n   = acc_q ^ (mplier_q[0] ? mcand_q : '0);
        mcand_n = ((mcand_q << 1) & emask_i)
                ^ (((mcand_q & top_bit) != '0) ? red_i : '0);
    end

    // Load masked operands, iterate, and capture the final sum.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mcand_q  <= '0;
            mplier_q <= '0;
            acc_q    <= '0;
            addend_q <= '0;
            result_o <= '0;
        end else if (load_i) begin
            mcand_q  <= a_i & emask_i;
            mplier_q <= b_i & emask_i;
            addend_q <= c_i & emask_i;
            acc_q    <= '0;
        end else if (step_i) begin
            acc_q    <= acc_n;
            mcand_q  <= mcand_n;
            mplier_q <= mplier_q >> 1;
            if (last_i) result_o <= acc_n ^ addend_q;
        end
    end

    // R5: working values stay inside the field during an operation.
    a_r5_work_in_field: assert property (@(posedge clk) disable iff (!rst_n)
        step_i |-> (((acc_q | mcand_q | mplier_q) & ~emask_i) == '0));

endmodule

// File: rtl/gfm_mac.sv
// Module: gfm_mac (top)
// GF(2^m) multiply-add: result = (A*B mod g) ^ C, one multiplier bit per
// clock. Configuration writes are accepted only when idle and not in the
// same cycle as start. Assumes XLEN >= 2.
module gfm_mac #(
    parameter int XLEN = 8,
    localparam int DW  = $clog2(XLEN + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_we,
    input  logic [XLEN-1:0] cfg_poly,
    input  logic            start,
    input  logic [XLEN-1:0] op_a,
    input  logic [XLEN-1:0] op_b,
    input  logic [XLEN-1:0] op_c,
    output logic            busy,
    output logic            done,
    output logic [XLEN-1:0] result
);

    logic            cfg_take;
    logic [DW-1:0]   deg;
    logic [XLEN-1:0] red;
    logic [XLEN-1:0] emask;
    logic            load;
    logic            step;
    logic            last;

    // Qualify configuration writes: never during or at the start of an operation.
    always_comb begin
        cfg_take = cfg_we && !busy && !start;
    end

    gfm_field_cfg #(.XLEN(XLEN)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_take),
        .wr_word (cfg_poly),
        .deg_o   (deg),
        .red_o   (red),
        .emask_o (emask)
    );

    gfm_seq #(.XLEN(XLEN)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start),
        .deg_i   (deg),
        .load_o  (load),
        .step_o  (step),
        .last_o  (last),
        .busy_o  (busy),
        .done_o  (done)
    );

    gfm_datapath #(.XLEN(XLEN)) u_dp (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (load),
        .step_i   (step),
        .last_i   (last),
        .a_i      (op_a),
        .b_i      (op_b),
        .c_i      (op_c),
        .red_i    (red),
        .emask_i  (emask),
        .result_o (result)
    );

    // R7: result only moves when done is raised.
    a_r7_result_held: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(result));

    // R9: field description is frozen across a busy cycle.
    a_r9_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(deg) && $stable(red)));

    // R9: a write presented together with start is not taken.
    a_r9_start_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> $stable(deg));

    // R5: the result never holds a bit outside the field.
    a_r5_result_in_field: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((result & ~emask) == '0));

endmodule

// File: tb/gfm_mac_bench.sv
`timescale 1ns/1ps
module gfm_mac_bench;

    localparam int XLEN = 8;
    localparam int PW   = 2 * XLEN;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cfg_we = 1'b0;
    logic [XLEN-1:0] cfg_poly = '0;
    logic            start = 1'b0;
    logic [XLEN-1:0] op_a = '0;
    logic [XLEN-1:0] op_b = '0;
    logic [XLEN-1:0] op_c = '0;
    logic            busy;
    logic            done;
    logic [XLEN-1:0] result;

    int n_cmp = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    gfm_mac #(.XLEN(XLEN)) u_gfm_mac (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_poly(cfg_poly),
        .start(start), .op_a(op_a), .op_b(op_b), .op_c(op_c),
        .busy(busy), .done(done), .result(result)
    );

    // Full reducing polynomial (XLEN+1 bits) from the configuration word.
    function automatic logic [PW-1:0] ref_full(input logic [XLEN-1:0] w);
        if (w < 3) return PW'(2);
        if (!w[0]) return (PW'(1) << XLEN) | PW'(w) | PW'(1);
        return PW'(w);
    endfunction

    function automatic int ref_deg(input logic [XLEN-1:0] w);
        logic [PW-1:0] f;
        int d;
        f = ref_full(w);
        d = 0;
        for (int i = 0; i < PW; i++) if (f[i]) d = i;
        return d;
    endfunction

    // Carry-less product then polynomial long division remainder, plus addend.
    function automatic logic [XLEN-1:0] ref_res(input logic [XLEN-1:0] w,
        input logic [XLEN-1:0] a, input logic [XLEN-1:0] b, input logic [XLEN-1:0] c);
        logic [PW-1:0] f, m, p, am, bm, cm;
        int d;
        f  = ref_full(w);
        d  = ref_deg(w);
        m  = (PW'(1) << d) - PW'(1);
        am = PW'(a) & m;
        bm = PW'(b) & m;
        cm = PW'(c) & m;
        p  = '0;
        for (int i = 0; i < XLEN; i++) if (bm[i]) p = p ^ (am << i);
        for (int i = PW - 1; i >= d; i--) if (p[i]) p = p ^ (f << (i - d));
        return XLEN'(p ^ cm);
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic write_cfg(input logic [XLEN-1:0] w);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_poly = w;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Wait for done; returns cycles counted from the accepting edge.
    task automatic wait_done(output int lat);
        lat = 0;
        while (!done && lat < 64) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic run_op(input logic [XLEN-1:0] a, input logic [XLEN-1:0] b,
                          input logic [XLEN-1:0] c, output logic [XLEN-1:0] r,
                          output int lat);
        @(negedge clk);
        start = 1'b1;
        op_a = a; op_b = b; op_c = c;
        @(negedge clk);
        start = 1'b0;
        wait_done(lat);
        r = result;
    endtask

    task automatic op_check(input string tag, input logic [XLEN-1:0] w,
                            input logic [XLEN-1:0] a, input logic [XLEN-1:0] b,
                            input logic [XLEN-1:0] c, input bit chk_lat);
        logic [XLEN-1:0] r;
        int lat;
        run_op(a, b, c, r, lat);
        check(tag, int'(r), int'(ref_res(w, a, b, c)));
        if (chk_lat) check({tag, " R6 latency"}, lat, ref_deg(w));
    endtask

    initial begin
        #(4 * 190000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [XLEN-1:0] r;
        logic [XLEN-1:0] held;
        int lat;

        repeat (4) @(negedge clk);
        // R1: reset state
        check("R1 busy", int'(busy), 0);
        check("R1 done", int'(done), 0);
        check("R1 result", int'(result), 0);
        rst_n = 1'b1;
        // R1: default field is GF(2), one-cycle op
        run_op(8'hFF, 8'hFD, 8'h00, r, lat);
        check("R1 default field result", int'(r), 1);
        check("R1 default field latency", lat, 1);

        // R2: degenerate words select polynomial x
        for (int w = 0; w < 3; w++) begin
            write_cfg(XLEN'(w));
            for (int k = 0; k < 8; k++)
                op_check("R2 gf2", XLEN'(w), XLEN'($urandom), XLEN'($urandom),
                         XLEN'($urandom), 1'b1);
        end

        // R10: small field, known product and exhaustive sweep
        write_cfg(8'h0B);
        run_op(8'h07, 8'h05, 8'h00, r, lat);
        check("R10 7*5", int'(r), 6);
        check("R10 latency", lat, 3);
        for (int a = 0; a < 8; a++)
            for (int b = 0; b < 8; b++)
                op_check("R10 R5 sweep", 8'h0B, XLEN'(a), XLEN'(b),
                         XLEN'($urandom), 1'b0);

        // R11: wide field with LSB-clear encoding
        write_cfg(8'h1A);
        run_op(8'h80, 8'h83, 8'h00, r, lat);
        check("R11 80*83", int'(r), 1);
        check("R11 R4 latency", lat, 8);
        for (int a = 0; a < 256; a++) begin
            op_check("R11 b02", 8'h1A, XLEN'(a), 8'h02, 8'h00, 1'b0);
            op_check("R11 b53", 8'h1A, XLEN'(a), 8'h53, XLEN'($urandom), 1'b0);
            op_check("R11 bFF", 8'h1A, XLEN'(a), 8'hFF, XLEN'(a), 1'b0);
        end

        // R3 R4 R5 R6: every configuration word with random full-width operands
        for (int w = 0; w < 256; w++) begin
            write_cfg(XLEN'(w));
            for (int k = 0; k < 6; k++)
                op_check("R3 R4 R5 cfg sweep", XLEN'(w), XLEN'($urandom),
                         XLEN'($urandom), XLEN'($urandom), 1'b1);
        end

        // R8: second start while busy is ignored
        write_cfg(8'h1A);
        @(negedge clk);
        start = 1'b1; op_a = 8'h57; op_b = 8'h83; op_c = 8'h11;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        start = 1'b1; op_a = 8'hAA; op_b = 8'h55; op_c = 8'h00;
        @(negedge clk);
        start = 1'b0;
        wait_done(lat);
        check("R8 result", int'(result), int'(ref_res(8'h1A, 8'h57, 8'h83, 8'h11)));
        check("R8 latency", lat + 2, 8);

        // R7: result held while inputs change without start
        held = result;
        op_a = 8'hC3; op_b = 8'h3C; op_c = 8'hFF;
        repeat (6) @(negedge clk);
        check("R7 hold", int'(result), int'(held));

        // R9: write during busy is discarded
        write_cfg(8'h0B);
        @(negedge clk);
        start = 1'b1; op_a = 8'h06; op_b = 8'h03; op_c = 8'h01;
        @(negedge clk);
        start = 1'b0;
        cfg_we = 1'b1; cfg_poly = 8'h1A;
        @(negedge clk);
        cfg_we = 1'b0;
        wait_done(lat);
        check("R9 busy-write result", int'(result),
              int'(ref_res(8'h0B, 8'h06, 8'h03, 8'h01)));
        op_check("R9 field kept after busy write", 8'h0B, 8'hF5, 8'h6E, 8'h00, 1'b1);

        // R9: write together with start is discarded
        @(negedge clk);
        start = 1'b1; cfg_we = 1'b1; cfg_poly = 8'h1A;
        op_a = 8'h05; op_b = 8'h07; op_c = 8'h00;
        @(negedge clk);
        start = 1'b0; cfg_we = 1'b0;
        wait_done(lat);
        check("R9 same-cycle result", int'(result),
              int'(ref_res(8'h0B, 8'h05, 8'h07, 8'h00)));
        op_check("R9 field kept after same-cycle write", 8'h0B, 8'h3E, 8'hA7, 8'h02, 1'b1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule